// File: doc/BRIEF.md
# Configurable LVDS Sample Serializer

This block takes one 14-bit converter sample per sample period and turns it into a stream of bit slots on one or two serial data lanes. Next to the data it produces a frame marker and a bit-clock indication. Each bit slot stands for one half-cycle of a double-data-rate bit clock. The block runs in one fast clock domain, and a slot-enable input advances it by one slot. Five configuration inputs control the output:
- the number of lanes,
- how sample bits are spread across the two lanes,
- whether the two lanes are exchanged,
- the number format,
- whether the overrange flag replaces the least significant bit.

A frame is 14 slots long. The frame marker is high for the first 7 slots of each frame. In one-lane mode a frame carries one word, least significant bit first. In two-lane mode each lane carries 7 slots per sample, so one frame holds two samples and the marker runs at half the sample rate. The sample and the mapping options are captured into a holding register at the start of each word. Later input changes therefore never disturb the word already being shifted out. A change of lane count is applied only at a frame boundary, and both lanes are held at 0 until that boundary.

Top module: `ser_lane_serializer`

## Requirements
- R1: After reset `lane0`, `lane1`, `frameMark` and `bitClk` are all 0, and two-lane mode is active. The slot counter rests on the last slot (13), so the first `slotEn` starts a new frame at slot 0.
- R2: The block advances by exactly one slot on each clock with `slotEn` high, and all outputs hold while `slotEn` is low. Slots are numbered 0 to 13 within a frame. `frameMark` is 1 on slots 0 to 6 and 0 on slots 7 to 13. `bitClk` is 1 on even slots and 0 on odd slots, so it toggles on every slot.
- R3: With `cfgOneLane`=1, a word is captured at slot 0. On slot k, `lane0` carries word bit k (bit 0 on slot 0). `lane1` is 0 throughout.
- R4: With `cfgOneLane`=0, `cfgOddEven`=0 and `cfgLaneSwap`=0, a word is captured at slots 0 and 7. On word slot j (0 to 6), `lane0` carries word bit j and `lane1` carries word bit j+7.
- R5: With `cfgOddEven`=1 in two-lane mode, on word slot j `lane0` carries word bit 2j and `lane1` carries word bit 2j+1.
- R6: With `cfgLaneSwap`=1 in two-lane mode, the contents of `lane0` and `lane1` are exchanged. In one-lane mode the option has no effect.
- R7: With `cfgOffsetBin`=1 the word is the sample with bit 13 inverted (offset binary). With 0 the sample passes unchanged (twos complement).
- R8: With `cfgOvrOnLsb`=1, word bit 0 is `sampleOvr` instead of sample bit 0.
- R9: `sampleIn`, `sampleOvr`, `cfgOddEven`, `cfgLaneSwap`, `cfgOffsetBin` and `cfgOvrOnLsb` are sampled only on the slot-enable edge that starts a word. Changing them during a word does not alter that word's output.
- R10: When `cfgOneLane` differs from the active mode, both lanes are 0 from that cycle until the next frame boundary. This holds even if the input returns to the active value meanwhile. At the boundary the mode on `cfgOneLane` takes effect. A change presented right before the boundary edge therefore causes no muted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Synchronous reset, active low |
| slotEn | input | 1 | Advance by one bit slot |
| sampleIn | input | 14 | Converter sample |
| sampleOvr | input | 1 | Overrange flag of the sample |
| cfgOneLane | input | 1 | 1 = one lane, 0 = two lanes |
| cfgOddEven | input | 1 | Two-lane interleave by bit parity |
| cfgLaneSwap | input | 1 | Exchange the two lanes (two-lane only) |
| cfgOffsetBin | input | 1 | 1 = offset binary, 0 = twos complement |
| cfgOvrOnLsb | input | 1 | Put the overrange flag in bit 0 |
| lane0 | output | 1 | Serial lane 0 |
| lane1 | output | 1 | Serial lane 1 |
| frameMark | output | 1 | Frame marker, high for slots 0 to 6 |
| bitClk | output | 1 | Bit-clock indication, high on even slots |

## Verification
Two events can land on the same slot-enable edge: the lane-count switch and the word capture at the frame boundary. The bench presents a new `cfgOneLane` value in the idle cycle just before the boundary slot. It then expects the first slot of the new mode to carry live data instead of a muted 0. The bench also flips the lane count in mid-frame, and once flips it back before the boundary. In both cases it expects zeros on both lanes up to the boundary. During words it changes the sample and every mapping option, and it checks that the word already in flight stays intact.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int SAMPLE_W = 14;
  localparam int HALF_W   = SAMPLE_W / 2;
  localparam int IDX_W    = $clog2(SAMPLE_W);
  localparam int HIDX_W   = $clog2(HALF_W);

  typedef struct packed {
    logic             loadWord;
    logic             oneLane;
    logic             muted;
    logic [IDX_W-1:0] slotIdx;
  } serStrobe_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotEn,
  input  logic       cfgOneLane,
  output serStrobe_t strobes,
  output logic       frameMark,
  output logic       bitClk
);
  localparam logic [IDX_W-1:0] LastSlot = IDX_W'(SAMPLE_W - 1);
  localparam logic [IDX_W-1:0] HalfSlot = IDX_W'(HALF_W);

  logic [IDX_W-1:0] phase;
  logic [IDX_W-1:0] nextPhase;
  logic             activeOne;
  logic             muteR;
  logic             modeMismatch;
  logic             frameStart;
  logic             halfStart;

  assign nextPhase    = (phase == LastSlot) ? '0 : phase + 1'b1;
  assign frameStart   = (nextPhase == '0);
  assign halfStart    = (nextPhase == HalfSlot);
  assign modeMismatch = (cfgOneLane != activeOne);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= LastSlot;
      activeOne <= 1'b0;
      muteR     <= 1'b0;
    end else begin
      if (slotEn) phase <= nextPhase;
      if (slotEn && frameStart) begin
        activeOne <= cfgOneLane;
        muteR     <= 1'b0;
      end else if (modeMismatch) begin
        muteR <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadWord = slotEn && (frameStart || (!activeOne && halfStart));
    strobes.oneLane  = activeOne;
    strobes.muted    = muteR | modeMismatch;
    if (!activeOne && (phase >= HalfSlot))
      strobes.slotIdx = phase - HalfSlot;
    else
      strobes.slotIdx = phase;
  end

  assign frameMark = (phase < HalfSlot);
  assign bitClk    = ~phase[0];

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slotEn |=> ($stable(frameMark) && $stable(bitClk)));

  // R2
  bit_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotEn |=> (bitClk != $past(bitClk)));

  // R10
  mode_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeOne) |-> ($past(slotEn) && (phase == '0)));
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  serStrobe_t          strobes,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleOvr,
  input  logic                cfgOddEven,
  input  logic                cfgLaneSwap,
  input  logic                cfgOffsetBin,
  input  logic                cfgOvrOnLsb,
  output logic                lane0,
  output logic                lane1
);
  logic [SAMPLE_W-1:0] fmtWord;
  logic [SAMPLE_W-1:0] holdWord;
  logic                holdOdd;
  logic                holdSwap;
  logic [HALF_W-1:0]   seqLo, seqHi, evenBits, oddBits;
  logic [HIDX_W-1:0]   halfIdx;
  logic                bitA, bitB;

  always_comb begin
    fmtWord = sampleIn;
    fmtWord[SAMPLE_W-1] = sampleIn[SAMPLE_W-1] ^ cfgOffsetBin;
    if (cfgOvrOnLsb) fmtWord[0] = sampleOvr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWord <= '0;
      holdOdd  <= 1'b0;
      holdSwap <= 1'b0;
    end else if (strobes.loadWord) begin
      holdWord <= fmtWord;
      holdOdd  <= cfgOddEven;
      holdSwap <= cfgLaneSwap;
    end
  end

  for (genvar k = 0; k < HALF_W; k++) begin : g_lanemap
    assign seqLo[k]    = holdWord[k];
    assign seqHi[k]    = holdWord[k + HALF_W];
    assign evenBits[k] = holdWord[2*k];
    assign oddBits[k]  = holdWord[2*k + 1];
  end

  assign halfIdx = strobes.slotIdx[HIDX_W-1:0];

  always_comb begin
    if (strobes.oneLane) begin
      bitA = holdWord[strobes.slotIdx];
      bitB = 1'b0;
    end else if (holdOdd) begin
      bitA = evenBits[halfIdx];
      bitB = oddBits[halfIdx];
    end else begin
      bitA = seqLo[halfIdx];
      bitB = seqHi[halfIdx];
    end
    if (strobes.muted) begin
      lane0 = 1'b0;
      lane1 = 1'b0;
    end else if (holdSwap && !strobes.oneLane) begin
      lane0 = bitB;
      lane1 = bitA;
    end else begin
      lane0 = bitA;
      lane1 = bitB;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadWord |=> ($stable(holdWord) && $stable(holdOdd) && $stable(holdSwap)));
endmodule

// File: rtl/ser_lane_serializer.sv
module ser_lane_serializer
  import ser_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                slotEn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleOvr,
  input  logic                cfgOneLane,
  input  logic                cfgOddEven,
  input  logic                cfgLaneSwap,
  input  logic                cfgOffsetBin,
  input  logic                cfgOvrOnLsb,
  output logic                lane0,
  output logic                lane1,
  output logic                frameMark,
  output logic                bitClk
);
  serStrobe_t strobes;

  ser_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slotEn     (slotEn),
    .cfgOneLane (cfgOneLane),
    .strobes    (strobes),
    .frameMark  (frameMark),
    .bitClk     (bitClk)
  );

  ser_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .sampleIn     (sampleIn),
    .sampleOvr    (sampleOvr),
    .cfgOddEven   (cfgOddEven),
    .cfgLaneSwap  (cfgLaneSwap),
    .cfgOffsetBin (cfgOffsetBin),
    .cfgOvrOnLsb  (cfgOvrOnLsb),
    .lane0        (lane0),
    .lane1        (lane1)
  );

  // R3
  one_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.oneLane && $past(strobes.oneLane)) |-> !lane1);
endmodule

// File: tb/tb_ser_lane_serializer.sv
module tb_ser_lane_serializer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotEn = 1'b0;
  logic [13:0] sampleIn = '0;
  logic sampleOvr = 1'b0;
  logic cfgOneLane = 1'b0, cfgOddEven = 1'b0, cfgLaneSwap = 1'b0;
  logic cfgOffsetBin = 1'b0, cfgOvrOnLsb = 1'b0;
  logic lane0, lane1, frameMark, bitClk;

  int total = 0;
  int bad = 0;
  int tbPhase = 13;

  always #10 clk = ~clk;

  ser_lane_serializer dut (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .sampleIn(sampleIn),
    .sampleOvr(sampleOvr), .cfgOneLane(cfgOneLane), .cfgOddEven(cfgOddEven),
    .cfgLaneSwap(cfgLaneSwap), .cfgOffsetBin(cfgOffsetBin),
    .cfgOvrOnLsb(cfgOvrOnLsb), .lane0(lane0), .lane1(lane1),
    .frameMark(frameMark), .bitClk(bitClk)
  );

  task automatic check4(input string tag, input logic e0, input logic e1,
                        input logic eF, input logic eB);
    total++;
    if (lane0 !== e0 || lane1 !== e1 || frameMark !== eF || bitClk !== eB) begin
      bad++;
      $display("FAIL %s slot=%0d got l0=%b l1=%b fm=%b bc=%b exp l0=%b l1=%b fm=%b bc=%b",
               tag, tbPhase, lane0, lane1, frameMark, bitClk, e0, e1, eF, eB);
    end
  endtask

  // one slot pulse, then an idle cycle; returns at a falling edge
  task automatic stepCheck(input string tag, input logic e0, input logic e1);
    slotEn = 1'b1;
    @(negedge clk);
    slotEn = 1'b0;
    @(negedge clk);
    tbPhase = (tbPhase + 1) % 14;
    check4(tag, e0, e1, tbPhase < 7, (tbPhase % 2) == 0);
  endtask

  function automatic logic [13:0] makeWord(input logic [13:0] s, input logic ovr,
                                           input logic fmt, input logic ovrEn);
    logic [13:0] w;
    w = s;
    w[13] = s[13] ^ fmt;
    if (ovrEn) w[0] = ovr;
    return w;
  endfunction

  // runs one whole word; the inputs are scrambled after slot 2 (R9)
  task automatic runWord(input string tag, input logic [13:0] s, input logic ovr,
                         input logic one, input logic oe, input logic sw,
                         input logic fmt, input logic ovrEn);
    logic [13:0] w;
    logic a, b;
    int n;
    w = makeWord(s, ovr, fmt, ovrEn);
    sampleIn = s; sampleOvr = ovr; cfgOneLane = one; cfgOddEven = oe;
    cfgLaneSwap = sw; cfgOffsetBin = fmt; cfgOvrOnLsb = ovrEn;
    n = one ? 14 : 7;
    for (int k = 0; k < n; k++) begin
      if (one) begin
        a = w[k]; b = 1'b0;
      end else begin
        a = oe ? w[2*k] : w[k];
        b = oe ? w[2*k+1] : w[k+7];
        if (sw) begin
          logic t;
          t = a; a = b; b = t;
        end
      end
      stepCheck(tag, a, b);
      if (k == 2) begin
        sampleIn = ~s; sampleOvr = ~ovr; cfgOddEven = ~oe; cfgLaneSwap = ~sw;
        cfgOffsetBin = ~fmt; cfgOvrOnLsb = ~ovrEn;
      end
    end
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check4("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    // R2 no slot enable: nothing moves
    check4("R2", 1'b0, 1'b0, 1'b0, 1'b0);

    // R4 / R5 / R6 two-lane mapping sweep (even count keeps frame alignment)
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 8; i++) begin
        logic [13:0] s;
        s = 14'((i * 2731 + c * 977 + 5) & 16'h3fff);
        if (i == 0) s = 14'h3fff;
        if (i == 1) s = 14'h2aaa;
        runWord(c == 0 ? "R4" : (c == 1 ? "R5" : (c == 2 ? "R6" : "R5_R6")),
                s, 1'b0, 1'b0, c[0], c[1], 1'b0, 1'b0);
      end
    end

    // R7 / R8 formatting in two-lane mode
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 4; i++) begin
        runWord(c[0] ? (c[1] ? "R7_R8" : "R7") : (c[1] ? "R8" : "R4"),
                14'((i * 4099 + 8191) & 16'h3fff), i[0], 1'b0, 1'b0, 1'b0,
                c[0], c[1]);
      end
    end

    // R3 one-lane words; the switch lands on the boundary edge (R10)
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 2; i++) begin
        runWord(c[2] ? "R3_R6" : "R3", 14'((c * 1543 + i * 6007 + 17) & 16'h3fff),
                ~i[0], 1'b1, 1'b0, c[2], c[0], c[1]);
      end
    end

    // R10 two-lane word after a boundary switch, then a mid-frame switch
    runWord("R10", 14'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runWord("R10", 14'h0f0f, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sampleIn = 14'h3fff; cfgOneLane = 1'b0; cfgOddEven = 1'b0; cfgLaneSwap = 1'b0;
    cfgOffsetBin = 1'b0; cfgOvrOnLsb = 1'b0;
    for (int k = 0; k < 3; k++) stepCheck("R10", 1'b1, 1'b1);
    cfgOneLane = 1'b1;
    @(negedge clk);
    check4("R10", 1'b0, 1'b0, tbPhase < 7, (tbPhase % 2) == 0);
    for (int k = 3; k < 14; k++) stepCheck("R10", 1'b0, 1'b0);
    runWord("R10", 14'h2d4b, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R10 flip away and back mid-frame: still muted to the boundary
    sampleIn = 14'h3fff; sampleOvr = 1'b1;
    for (int k = 0; k < 4; k++) stepCheck("R3", 1'b1, 1'b0);
    cfgOneLane = 1'b0;
    for (int k = 4; k < 6; k++) stepCheck("R10", 1'b0, 1'b0);
    cfgOneLane = 1'b1;
    for (int k = 6; k < 14; k++) stepCheck("R10", 1'b0, 1'b0);
    runWord("R10", 14'h15a5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule